// File: doc/BRIEF.md
# Trigger-Controlled Up-Counter

This block is a prescaled up-counter whose behaviour is governed by a single synchronous trigger input. A 4-bit mode code decides how the trigger acts on the count. The trigger can do nothing, clear the count, gate it, start it, or act as the count clock. Two modes combine clearing with starting, or with gating. The counter runs from zero up to a reload limit and then wraps to zero. Each wrap and each trigger-induced clear raises a one-cycle update pulse.

A prescaler sits between the count source and the counter. It divides the selected count source by the prescaler value plus one. The count source is the internal clock, gated or not, or the trigger edges in external clock mode. A clear requested by the trigger resets the prescaler as well as the counter.

Top module: `tmr_slave_ctl`

## Requirements
- R1: While rst_n is low, cnt_o is 0 and upd_o is 0.
- R2: In mode 0000 with cnt_en_i high, every clock is a count source tick. Every psc_i+1 ticks the counter advances by one. When it advances from arr_i it becomes 0, and upd_o is 1 in the cycle that cnt_o shows that 0.
- R3: Codes 0001, 0010, 0011 and 1010 to 1111 behave exactly like mode 0000. The trigger has no effect in them.
- R4: In mode 0000 with cnt_en_i low, cnt_o holds its value and upd_o stays 0.
- R5: Mode 0100 (clear on edge): a clock where trig_i is 1 after being 0 on the previous clock is a rising edge. On the next cycle cnt_o is 0 and upd_o is 1, and the prescaler restarts from zero. Otherwise the counter counts as in R2.
- R6: Mode 0101 (gated): ticks occur only in cycles where cnt_en_i and trig_i are both 1. While trig_i is 0, cnt_o holds.
- R7: Mode 0110 (start on edge): a rising edge latches an internal run flag without clearing the counter. Ticks occur when cnt_en_i or the run flag is 1, so counting begins the cycle after the edge and continues after trig_i falls.
- R8: Mode 0111 (edge clock): with cnt_en_i high, each rising edge of trig_i is exactly one tick. The level of trig_i causes no tick.
- R9: Mode 1000 (clear and start): a rising edge clears the counter and prescaler, pulses upd_o and latches the run flag. After that, ticks follow R7.
- R10: Mode 1001 (gated with clear): counting follows R6. A falling edge of trig_i (1 then 0) makes cnt_o 0 with upd_o 1 on the next cycle.
- R11: upd_o is 1 only in a cycle where cnt_o is 0, following a wrap or a trigger-induced clear, and it is 0 otherwise.
- R12: The run flag is cleared whenever the mode is neither 0110 nor 1000. After leaving such a mode with cnt_en_i low, the counter holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en_i | input | 1 | Counter enable |
| mode_i | input | 4 | Trigger mode code |
| trig_i | input | 1 | Synchronous trigger |
| psc_i | input | PW | Prescaler divide value minus one |
| arr_i | input | CW | Reload limit |
| cnt_o | output | CW | Counter value |
| upd_o | output | 1 | One-cycle update pulse |

## Verification
The assertions check the following on every cycle:
- An update pulse always coincides with a zero count.
- The count holds in gated mode while the trigger is low.
- The count holds in the disabled mode while the enable is low.
- Between edges in edge-clock mode the count does not move.
- Rising edges in clear mode and falling edges in gated-clear mode zero the count with an update.

Only the bench scenarios can show the rest:
- The prescaler division ratio and exact wrap points.
- That the run flag persists after a start edge and is dropped on leaving the start modes.
- That reserved codes match the disabled mode.
- The arithmetic of mixed random mode sequences.

// File: rtl/tsm_pkg.sv
package tsm_pkg;
  typedef enum logic [3:0] {
    SM_OFF      = 4'b0000,
    SM_RST      = 4'b0100,
    SM_GATE     = 4'b0101,
    SM_TRIG     = 4'b0110,
    SM_EXT      = 4'b0111,
    SM_RSTTRIG  = 4'b1000,
    SM_GATERST  = 4'b1001
  } sm_mode_e;

  typedef struct packed {
    logic gate;      // tick only while trigger high
    logic start;     // rising edge latches run flag
    logic ext;       // rising edges are the tick source
    logic clr_rise;  // rising edge clears counter
    logic clr_fall;  // falling edge clears counter
  } sm_ctl_t;
endpackage

// File: rtl/tsm_edge.sv
module tsm_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_i,
  output logic rise_o,
  output logic fall_o
);
  logic trig_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trig_q <= 1'b0;
    else        trig_q <= trig_i;
  end

  assign rise_o = trig_i & ~trig_q;
  assign fall_o = ~trig_i & trig_q;
endmodule

// File: rtl/tsm_decode.sv
module tsm_decode
  import tsm_pkg::*;
(
  input  logic [3:0] mode_i,
  output sm_ctl_t    ctl_o
);
  always_comb begin
    ctl_o = '0;
    case (mode_i)
      SM_RST:     ctl_o.clr_rise = 1'b1;
      SM_GATE:    ctl_o.gate     = 1'b1;
      SM_TRIG:    ctl_o.start    = 1'b1;
      SM_EXT:     ctl_o.ext      = 1'b1;
      SM_RSTTRIG: begin
        ctl_o.start    = 1'b1;
        ctl_o.clr_rise = 1'b1;
      end
      SM_GATERST: begin
        ctl_o.gate     = 1'b1;
        ctl_o.clr_fall = 1'b1;
      end
      default:    ctl_o = '0;
    endcase
  end
endmodule

// File: rtl/tsm_count.sv
module tsm_count #(
  parameter int CW = 16,
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reinit_i,
  input  logic          tick_i,
  input  logic [PW-1:0] psc_i,
  input  logic [CW-1:0] arr_i,
  output logic [CW-1:0] cnt_o,
  output logic          upd_o
);
  localparam logic [CW-1:0] CNT_ONE = CW'(1);
  localparam logic [PW-1:0] PSC_ONE = PW'(1);

  logic [PW-1:0] psc_q, psc_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          upd_q, upd_d;
  logic          psc_done;

  assign psc_done = (psc_q >= psc_i);

  always_comb begin
    psc_d = psc_q;
    cnt_d = cnt_q;
    upd_d = 1'b0;
    if (reinit_i) begin
      psc_d = '0;
      cnt_d = '0;
      upd_d = 1'b1;
    end else if (tick_i) begin
      if (psc_done) begin
        psc_d = '0;
        if (cnt_q >= arr_i) begin
          cnt_d = '0;
          upd_d = 1'b1;
        end else begin
          cnt_d = cnt_q + CNT_ONE;
        end
      end else begin
        psc_d = psc_q + PSC_ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psc_q <= '0;
      cnt_q <= '0;
      upd_q <= 1'b0;
    end else begin
      psc_q <= psc_d;
      cnt_q <= cnt_d;
      upd_q <= upd_d;
    end
  end

  assign cnt_o = cnt_q;
  assign upd_o = upd_q;
endmodule

// File: rtl/tmr_slave_ctl.sv
module tmr_slave_ctl
  import tsm_pkg::*;
#(
  parameter int CW = 16,
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cnt_en_i,
  input  logic [3:0]    mode_i,
  input  logic          trig_i,
  input  logic [PW-1:0] psc_i,
  input  logic [CW-1:0] arr_i,
  output logic [CW-1:0] cnt_o,
  output logic          upd_o
);
  logic    rise, fall;
  sm_ctl_t ctl;
  logic    run_q, run_d;
  logic    tick, reinit;

  tsm_edge u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .trig_i (trig_i),
    .rise_o (rise),
    .fall_o (fall)
  );

  tsm_decode u_dec (
    .mode_i (mode_i),
    .ctl_o  (ctl)
  );

  always_comb begin
    run_d = ctl.start ? (run_q | rise) : 1'b0;
    if (ctl.ext)        tick = cnt_en_i & rise;
    else if (ctl.gate)  tick = cnt_en_i & trig_i;
    else if (ctl.start) tick = cnt_en_i | run_q;
    else                tick = cnt_en_i;
    reinit = (ctl.clr_rise & rise) | (ctl.clr_fall & fall);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= 1'b0;
    else        run_q <= run_d;
  end

  tsm_count #(.CW(CW), .PW(PW)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .reinit_i (reinit),
    .tick_i   (tick),
    .psc_i    (psc_i),
    .arr_i    (arr_i),
    .cnt_o    (cnt_o),
    .upd_o    (upd_o)
  );
endmodule

// File: rtl/tmr_slave_ctl_chk.sv
module tmr_slave_ctl_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cnt_en_i,
  input logic [3:0]    mode_i,
  input logic          trig_i,
  input logic [CW-1:0] cnt_o,
  input logic          upd_o
);
  logic trig_d;
  logic off_cls;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trig_d <= 1'b0;
    else        trig_d <= trig_i;
  end

  assign off_cls = (mode_i == 4'b0000) || (mode_i inside {4'b0001, 4'b0010, 4'b0011})
                   || (mode_i >= 4'b1010);

  // R11
  upd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_o |-> (cnt_o == '0));

  // R4
  off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (off_cls && !cnt_en_i) |=> ($stable(cnt_o) && !upd_o));

  // R6
  gate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 4'b0101 && !trig_i) |=> $stable(cnt_o));

  // R5
  rise_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 4'b0100 && trig_i && !trig_d) |=> (cnt_o == '0 && upd_o));

  // R10
  fall_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 4'b1001 && !trig_i && trig_d) |=> (cnt_o == '0 && upd_o));

  // R8
  ext_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 4'b0111 && !(trig_i && !trig_d)) |=> $stable(cnt_o));
endmodule

bind tmr_slave_ctl tmr_slave_ctl_chk #(.CW(CW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cnt_en_i (cnt_en_i),
  .mode_i   (mode_i),
  .trig_i   (trig_i),
  .cnt_o    (cnt_o),
  .upd_o    (upd_o)
);

// File: tb/tmr_slave_ctl_test.sv
module tmr_slave_ctl_test;
  localparam int CW = 16;
  localparam int PW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cnt_en;
  logic [3:0]    mode;
  logic          trig;
  logic [PW-1:0] psc;
  logic [CW-1:0] arr;
  logic [CW-1:0] cnt;
  logic          upd;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  tmr_slave_ctl #(.CW(CW), .PW(PW)) uut (
    .clk (clk), .rst_n (rst_n), .cnt_en_i (cnt_en), .mode_i (mode),
    .trig_i (trig), .psc_i (psc), .arr_i (arr), .cnt_o (cnt), .upd_o (upd)
  );

  // reference model built from the requirements
  logic [CW-1:0] m_cnt;
  logic [PW-1:0] m_psc;
  logic          m_tq, m_run, m_upd;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt <= '0; m_psc <= '0; m_tq <= 1'b0; m_run <= 1'b0; m_upd <= 1'b0;
    end else begin
      logic r, f, tk, clr, st;
      r  = trig & !m_tq;
      f  = !trig & m_tq;
      st = (mode == 4'b0110) || (mode == 4'b1000);
      case (mode)
        4'b0101, 4'b1001: tk = cnt_en & trig;
        4'b0110, 4'b1000: tk = cnt_en | m_run;
        4'b0111:          tk = cnt_en & r;
        default:          tk = cnt_en;
      endcase
      clr = ((mode == 4'b0100 || mode == 4'b1000) && r) || (mode == 4'b1001 && f);
      m_run <= st ? (m_run | r) : 1'b0;
      m_tq  <= trig;
      m_upd <= 1'b0;
      if (clr) begin
        m_cnt <= '0; m_psc <= '0; m_upd <= 1'b1;
      end else if (tk) begin
        if (m_psc >= psc) begin
          m_psc <= '0;
          if (m_cnt >= arr) begin m_cnt <= '0; m_upd <= 1'b1; end
          else m_cnt <= m_cnt + 1'b1;
        end else m_psc <= m_psc + 1'b1;
      end
    end
  end

  function automatic string tag_of(logic [3:0] m, logic en);
    case (m)
      4'b0000: return en ? "R2" : "R4";
      4'b0100: return "R5";
      4'b0101: return "R6";
      4'b0110: return "R7";
      4'b0111: return "R8";
      4'b1000: return "R9";
      4'b1001: return "R10";
      default: return "R3";
    endcase
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(string tag);
    @(posedge clk);
    @(negedge clk);
    chk(tag, int'(cnt), int'(m_cnt));
    chk("R11", int'(upd), int'(m_upd));
  endtask

  // enm: 0 low, 1 high, 2 random
  task automatic phase(logic [3:0] m, int n, string tag, int rate, int enm);
    mode = m;
    for (int i = 0; i < n; i++) begin
      if (int'($urandom % 100) < rate) trig = ~trig;
      cnt_en = (enm == 2) ? 1'($urandom % 2) : 1'(enm);
      step(tag);
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; cnt_en = 1'b1; mode = 4'b0000; trig = 1'b0;
    psc = '0; arr = 16'd5;
    repeat (3) @(negedge clk);
    chk("R1", int'(cnt), 0);
    chk("R1", int'(upd), 0);
    rst_n = 1'b1;

    // R2 free run, several divide ratios, arr=0 corner
    phase(4'b0000, 30, "R2", 20, 1);
    psc = 16'd2; arr = 16'd3;
    phase(4'b0000, 40, "R2", 20, 1);
    psc = 16'd0; arr = 16'd0;
    phase(4'b0000, 10, "R2", 0, 1);
    // R4 hold
    psc = 16'd1; arr = 16'd6;
    phase(4'b0000, 20, "R4", 30, 0);
    // R3 reserved codes
    phase(4'b0001, 20, "R3", 40, 1);
    phase(4'b0011, 20, "R3", 40, 1);
    phase(4'b1010, 20, "R3", 40, 1);
    phase(4'b1111, 20, "R3", 40, 1);
    // R5 clear on rising edge
    psc = 16'd1; arr = 16'd7;
    phase(4'b0100, 80, "R5", 15, 1);
    // R6 gated
    phase(4'b0101, 80, "R6", 15, 1);
    // R7 start on edge with enable low
    trig = 1'b0;
    phase(4'b0110, 5, "R7", 0, 0);
    trig = 1'b1;
    phase(4'b0110, 60, "R7", 5, 0);
    // R12 run flag dropped on leaving
    phase(4'b0000, 15, "R12", 30, 0);
    phase(4'b0110, 15, "R12", 0, 0);
    // R8 edge clock
    psc = 16'd1; arr = 16'd4;
    phase(4'b0111, 80, "R8", 40, 1);
    // R9 clear and start
    phase(4'b1000, 80, "R9", 10, 0);
    // R10 gated with clear
    psc = 16'd0; arr = 16'd9;
    phase(4'b1001, 80, "R10", 15, 1);

    // random mixture
    for (int k = 0; k < 40; k++) begin
      logic [3:0] rm;
      int en;
      rm  = 4'($urandom % 16);
      en  = int'($urandom % 3);
      psc = PW'($urandom % 4);
      arr = CW'($urandom % 10);
      phase(rm, 12, tag_of(rm, en != 0), 25, en);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule